// File: doc/BRIEF.md
# Serial Register Command Processor

This block lets a management processor read and write a bank of registers over a single pair of serial lines. The processor sends fixed seven-octet command frames on the receive line. The block recovers the bit rate from the first start bit it hears and assembles the octets. It then checks that the frame is addressed to it and that the checksum is intact, and performs one access on a simple register bus.

Each accepted command is answered with a seven-octet response on the transmit line, at the bit rate that was measured. A frame that is corrupt or meant for another controller gets no answer and causes no register access. Timeouts on the receive line realign the frame parser and let the bit rate be measured again.

Top module: `cmdlink_top`

## Requirements
- R1: Both lines carry octets with one low start bit, eight data bits sent least significant bit first, and one high stop bit. The lines idle high. A frame is seven octets: command, register address, four data octets (most significant octet first), checksum.
- R2: While no rate is locked, the low time of the next start bit is measured in clock cycles and becomes the bit period for receiving and transmitting. The first octet measured must have data bit 0 set, as every valid command does.
- R3: A command is accepted only if bits [7:5] equal 3'b010 and bit 4 is 0. Commands with bits [7:5] equal to 3'b001 or 3'b100 produce no response and no register access.
- R4: Command bits [3:2] must equal the `dev_id` input. A mismatch produces no response and no register access.
- R5: Command bits [1:0] = 2'b11 is a write. It gives a one-cycle `reg_wr` pulse carrying the address octet and the 32-bit data field. The response echoes the command, address and written data. Opcodes 2'b00 and 2'b10 are discarded silently.
- R6: Command bits [1:0] = 2'b01 is a read. It gives a one-cycle `reg_rd` pulse. `reg_rdata` is taken at the second rising edge after the one that raised `reg_rd`, which is one cycle of registered read latency. The response echoes the command and address and carries that value as its data field, so a narrow register appears right-aligned.
- R7: The checksum octet must equal the XOR of the six preceding octets. A mismatch discards the frame silently. The response checksum is the XOR of the response's first six octets.
- R8: A receive idle time of 16 bit periods after a stop bit resets the parser, so the next octet is taken as a command octet.
- R9: After 1024 idle bit periods the rate lock is released, and the next frame is measured afresh.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 2 | Strapped identifier compared with command bits [3:2] |
| rxd | input | 1 | Serial command input, idle high |
| txd | output | 1 | Serial response output, idle high |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register number for the access |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, one cycle of latency after `reg_rd` |

## Verification
A wrong bit-period count shows up as mis-sampled response bits within the first transmitted octet. The monitor samples at mid-bit using the rate the bench chose. A parser index that drifts out of step with the frames shows up as a missing response, and also as a missing write at the register model, within the next frame. A stale rate lock after the long idle shows up on the first frame sent at the new rate, because the octets are received wrongly and no reply arrives. A wrong checksum or a wrong latch of the read data is caught by the scoreboard comparison as soon as the response completes.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;
  localparam int FRAME_BYTES = 7;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
  localparam logic [2:0] OWN_TYPE = 3'b010;
  localparam logic [1:0] OP_WR    = 2'b11;
  localparam logic [1:0] OP_RD    = 2'b01;

  typedef enum logic [2:0] {RX_IDLE, RX_MEAS, RX_START, RX_DATA, RX_STOP} rx_st_t;
  typedef enum logic [1:0] {P_COLLECT, P_RD, P_WAIT} p_st_t;

  function automatic logic [7:0] xor6(input logic [47:0] six);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < 6; i++) acc = acc ^ six[8*i +: 8];
    return acc;
  endfunction

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [7:0] c, input logic [7:0] a,
                                                  input logic [31:0] d);
    return {c, a, d, xor6({c, a, d})};
  endfunction
endpackage

// File: rtl/cmdlink_rx.sv
module cmdlink_rx
  import cmdlink_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GAP_BITS   = 16,
  parameter int REARM_BITS = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             gap,
  output logic             locked,
  output logic [CNT_W-1:0] bit_per
);
  localparam int IB_W = $clog2(REARM_BITS + 1);

  logic [1:0]       sync;
  logic             rx_s;
  rx_st_t           st;
  logic [CNT_W-1:0] tmr, idle_clk;
  logic [IB_W-1:0]  idle_bits;
  logic [2:0]       nbit;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end
  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; tmr <= '0; bit_per <= '0; locked <= 1'b0; sh <= '0; nbit <= '0;
      rx_valid <= 1'b0; gap <= 1'b0; idle_clk <= '0; idle_bits <= '0; rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      gap      <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (!rx_s) begin
            idle_clk  <= '0;
            idle_bits <= '0;
            if (locked) begin
              st  <= RX_START;
              tmr <= {1'b0, bit_per[CNT_W-1:1]};
            end else begin
              st  <= RX_MEAS;
              tmr <= CNT_W'(1);
            end
          end else if (locked) begin
            if (idle_clk == bit_per - 1'b1) begin
              idle_clk  <= '0;
              idle_bits <= idle_bits + 1'b1;
              if (idle_bits == IB_W'(GAP_BITS - 1))   gap    <= 1'b1;
              if (idle_bits == IB_W'(REARM_BITS - 1)) locked <= 1'b0;
            end else begin
              idle_clk <= idle_clk + 1'b1;
            end
          end
        end
        RX_MEAS: begin
          if (rx_s) begin
            bit_per <= tmr;
            locked  <= 1'b1;
            st      <= RX_DATA;
            tmr     <= {1'b0, tmr[CNT_W-1:1]};
            nbit    <= '0;
          end else if (tmr != '1) begin
            tmr <= tmr + 1'b1;
          end
        end
        RX_START: begin
          if (tmr == '0) begin
            if (!rx_s) begin
              st   <= RX_DATA;
              tmr  <= bit_per - 1'b1;
              nbit <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else tmr <= tmr - 1'b1;
        end
        RX_DATA: begin
          if (tmr == '0) begin
            sh  <= {rx_s, sh[7:1]};
            tmr <= bit_per - 1'b1;
            if (nbit == 3'd7) st <= RX_STOP;
            else              nbit <= nbit + 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        RX_STOP: begin
          if (tmr == '0) begin
            if (rx_s) begin
              rx_byte  <= sh;
              rx_valid <= 1'b1;
            end
            st <= RX_IDLE;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R2: a locked rate is never a zero-length bit
  a_r2_lock_nonzero: assert property (@(posedge clk) disable iff (rst) locked |-> (bit_per != '0));
  // R9: lock is only released while the line is idle
  a_r9_unlock_idle: assert property (@(posedge clk) disable iff (rst) $fell(locked) |-> (st == RX_IDLE));
endmodule

// File: rtl/cmdlink_parser.sv
module cmdlink_parser
  import cmdlink_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         dev_id,
  input  logic [7:0]         rx_byte,
  input  logic               rx_valid,
  input  logic               gap,
  output logic               reg_wr,
  output logic               reg_rd,
  output logic [7:0]         reg_addr,
  output logic [31:0]        reg_wdata,
  input  logic [31:0]        reg_rdata,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_frame
);
  logic [47:0] sr;
  logic [2:0]  idx;
  p_st_t       st;
  logic [7:0]  cmd_q;
  logic [7:0]  c_cmd, c_addr;
  logic [31:0] c_data;
  logic        hdr_ok, accept, is_wr;

  always_comb begin
    c_cmd  = sr[47:40];
    c_addr = sr[39:32];
    c_data = sr[31:0];
    is_wr  = (c_cmd[1:0] == OP_WR);
    hdr_ok = (c_cmd[7:5] == OWN_TYPE) && !c_cmd[4] && (c_cmd[3:2] == dev_id) &&
             (is_wr || (c_cmd[1:0] == OP_RD));
    accept = hdr_ok && (xor6(sr) == rx_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; idx <= '0; st <= P_COLLECT; cmd_q <= '0;
      reg_wr <= 1'b0; reg_rd <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      tx_start <= 1'b0; tx_frame <= '0;
    end else begin
      reg_wr   <= 1'b0;
      reg_rd   <= 1'b0;
      tx_start <= 1'b0;
      case (st)
        P_COLLECT: begin
          if (gap) begin
            idx <= '0;
          end else if (rx_valid) begin
            if (idx == 3'(FRAME_BYTES - 1)) begin
              idx <= '0;
              if (accept) begin
                cmd_q    <= c_cmd;
                reg_addr <= c_addr;
                if (is_wr) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= c_data;
                  tx_start  <= 1'b1;
                  tx_frame  <= mk_frame(c_cmd, c_addr, c_data);
                end else begin
                  reg_rd <= 1'b1;
                  st     <= P_RD;
                end
              end
            end else begin
              sr  <= {sr[39:0], rx_byte};
              idx <= idx + 1'b1;
            end
          end
        end
        P_RD: st <= P_WAIT;
        P_WAIT: begin
          tx_start <= 1'b1;
          tx_frame <= mk_frame(cmd_q, reg_addr, reg_rdata);
          st       <= P_COLLECT;
        end
        default: st <= P_COLLECT;
      endcase
    end
  end

  // R10: strobes are mutually exclusive
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd));
  // R5: write strobe lasts one cycle
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr);
  // R6: read strobe lasts one cycle, response launched two cycles later
  a_r6_rd_pulse: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd);
  a_r6_rd_reply: assert property (@(posedge clk) disable iff (rst) reg_rd |=> ##1 tx_start);
endmodule

// File: rtl/cmdlink_tx.sv
module cmdlink_tx
  import cmdlink_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   bit_per,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               txd
);
  logic [FRAME_W-1:0] frm;
  logic [CNT_W-1:0]   tmr;
  logic [3:0]         bitn;
  logic [2:0]         bytn;
  logic [7:0]         cur;

  assign cur = frm[FRAME_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; txd <= 1'b1; tmr <= '0; bitn <= '0; bytn <= '0; frm <= '0;
    end else if (!busy) begin
      txd <= 1'b1;
      if (start) begin
        busy <= 1'b1;
        frm  <= frame;
        txd  <= 1'b0;
        tmr  <= bit_per - 1'b1;
        bitn <= '0;
        bytn <= '0;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else begin
      tmr <= bit_per - 1'b1;
      if (bitn == 4'd9) begin
        if (bytn == 3'(FRAME_BYTES - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bytn <= bytn + 1'b1;
          bitn <= '0;
          frm  <= {frm[FRAME_W-9:0], 8'h00};
          txd  <= 1'b0;
        end
      end else begin
        bitn <= bitn + 1'b1;
        txd  <= (bitn == 4'd8) ? 1'b1 : cur[bitn[2:0]];
      end
    end
  end

  // R1: line idles high between responses, every response opens with a start bit
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  a_r1_start_low: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !txd);
endmodule

// File: rtl/cmdlink_top.sv
module cmdlink_top
  import cmdlink_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GAP_BITS   = 16,
  parameter int REARM_BITS = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  dev_id,
  input  logic        rxd,
  output logic        txd,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic [7:0]  reg_addr,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata
);
  logic [7:0]         rx_byte;
  logic               rx_valid, gap, locked, tx_start, tx_busy;
  logic [CNT_W-1:0]   bit_per;
  logic [FRAME_W-1:0] tx_frame;

  cmdlink_rx #(.CNT_W(CNT_W), .GAP_BITS(GAP_BITS), .REARM_BITS(REARM_BITS)) u_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .gap(gap), .locked(locked), .bit_per(bit_per));

  cmdlink_parser u_parse (
    .clk(clk), .rst(rst), .dev_id(dev_id), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .gap(gap), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_start(tx_start), .tx_frame(tx_frame));

  cmdlink_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .bit_per(bit_per), .start(tx_start), .frame(tx_frame),
    .busy(tx_busy), .txd(txd));

  // R2: no response is launched before a rate has been measured
  a_r2_tx_needs_lock: assert property (@(posedge clk) disable iff (rst) tx_start |-> locked);
endmodule

// File: tb/sim_cmdlink_top.sv
module sim_cmdlink_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        txd, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  dev_id = 2'b10;

  int checks = 0;
  int fails  = 0;
  int bper   = 40;
  int wr_seen = 0;
  int both_seen = 0;
  bit done = 1'b0;

  logic [55:0] exp_q[$];
  logic [31:0] model [256];
  logic [31:0] shadow [256];

  always #2 clk = ~clk;

  cmdlink_top u0 (
    .clk(clk), .rst(rst), .dev_id(dev_id), .rxd(rxd), .txd(txd), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // register model: one cycle read latency; addresses >= 0x80 are 16 bits wide
  always @(posedge clk) begin
    if (reg_wr) model[reg_addr] <= reg_addr[7] ? {16'h0, reg_wdata[15:0]} : reg_wdata;
    if (reg_rd) reg_rdata <= model[reg_addr];
    if (!rst && reg_wr) wr_seen++;
    if (!rst && reg_wr && reg_rd) both_seen++;
  end

  function automatic logic [7:0] cks6(input logic [47:0] s);
    return s[47:40] ^ s[39:32] ^ s[31:24] ^ s[23:16] ^ s[15:8] ^ s[7:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0;
    repeat (bper) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bper) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * bper) @(negedge clk);
  endtask

  // driver: pushes the expected response (if any) then sends the command
  task automatic send_cmd(input logic [7:0] c, input logic [7:0] a, input logic [31:0] d,
                          input bit bad_cks, input bit expect_resp, input logic [31:0] rdat);
    logic [7:0] k;
    k = cks6({c, a, d}) ^ (bad_cks ? 8'h01 : 8'h00);
    if (expect_resp) exp_q.push_back({c, a, rdat, cks6({c, a, rdat})});
    send_byte(c);
    send_byte(a);
    for (int i = 3; i >= 0; i--) send_byte(d[8*i +: 8]);
    send_byte(k);
    repeat (90 * bper) @(negedge clk);
  endtask

  task automatic get_byte(output logic [7:0] b);
    while (txd !== 1'b0) @(negedge clk);
    repeat (bper / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bper) @(negedge clk);
      b[i] = txd;
    end
    repeat (bper) @(negedge clk);
    check("R1 stop bit", {63'd0, txd}, 64'd1);
  endtask

  // monitor: rebuilds response frames and compares with the scoreboard queue
  initial begin
    logic [55:0] f;
    logic [7:0]  b;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      for (int k = 0; k < 7; k++) begin
        get_byte(b);
        f = {f[47:0], b};
      end
      if (exp_q.size() == 0) check("R3/R4/R7 unexpected response", {8'd0, f}, 64'd0);
      else check("R5/R6/R7 response frame", {8'd0, f}, {8'd0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset txd", {63'd0, txd}, 64'd1);
    check("R10 reset reg_wr", {63'd0, reg_wr}, 64'd0);
    check("R6 reset reg_rd", {63'd0, reg_rd}, 64'd0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // R2 first frame measured at 40 clocks per bit; R5 write echo
    shadow[8'h05] = 32'hC0FFEE11;
    send_cmd(8'h4B, 8'h05, 32'hC0FFEE11, 1'b0, 1'b1, 32'hC0FFEE11);
    // R6 read back
    send_cmd(8'h49, 8'h05, 32'h0, 1'b0, 1'b1, shadow[8'h05]);
    // R6 narrow register right-aligned
    send_cmd(8'h4B, 8'h90, 32'hDEADBEEF, 1'b0, 1'b1, 32'hDEADBEEF);
    send_cmd(8'h49, 8'h90, 32'h0, 1'b0, 1'b1, 32'h0000BEEF);
    // R7 bad checksum, R3 other device types, R4 wrong id, R5 bad opcode: all silent
    send_cmd(8'h4B, 8'h05, 32'h11111111, 1'b1, 1'b0, 32'h0);
    send_cmd(8'h2B, 8'h05, 32'h22222222, 1'b0, 1'b0, 32'h0);
    send_cmd(8'h8B, 8'h05, 32'h33333333, 1'b0, 1'b0, 32'h0);
    send_cmd(8'h47, 8'h05, 32'h44444444, 1'b0, 1'b0, 32'h0);
    send_cmd(8'h4A, 8'h05, 32'h55555555, 1'b0, 1'b0, 32'h0);
    // register untouched by the discarded frames (R3 R4 R7)
    send_cmd(8'h49, 8'h05, 32'h0, 1'b0, 1'b1, shadow[8'h05]);

    // R8 partial frame, long gap, then a full frame is parsed from its first octet
    send_byte(8'h4B);
    send_byte(8'h07);
    send_byte(8'h11);
    repeat (20 * bper) @(negedge clk);
    send_cmd(8'h4B, 8'h07, 32'h12345678, 1'b0, 1'b1, 32'h12345678);

    // R9 long idle releases the lock; new rate of 24 clocks per bit
    repeat (1030 * 40) @(negedge clk);
    bper = 24;
    send_cmd(8'h4B, 8'h21, 32'hA5A55A5A, 1'b0, 1'b1, 32'hA5A55A5A);
    send_cmd(8'h49, 8'h21, 32'h0, 1'b0, 1'b1, 32'hA5A55A5A);

    check("R9/R8 all expected responses seen", 64'(exp_q.size()), 64'd0);
    check("R5 write strobe count", 64'(wr_seen), 64'd4);
    check("R10 overlapping strobes", 64'(both_seen), 64'd0);
    done = 1'b1;
    finish_run();
  end
endmodule